// File: doc/BRIEF.md
# FM Floppy Track Format Generator

This block produces the serial write stream used to format one track of a single-density floppy with 128-byte sectors. Each data bit is sent as a clock cell followed by a data cell. The cell period comes from a 1 MHz reference tick divided by a parameterised ratio, which is four for 4 µs cells. A start pulse latches the track number, side, sector count, data fill value and total track length. The generator then writes every sector with a fixed byte layout. Both address marks are sent with missing clock bits, and both CRC fields are computed on the fly.

No index pulse is used. After the last sector the block keeps writing gap filler until the programmed byte count is reached, or until a stop request ends the track at the next byte boundary. The write gate then drops and `done` pulses for one clock.

The output stream is paced only by the cell timer and cannot be stalled. The receiving write channel must take one cell at every cell boundary, so the stream has no valid/ready handshake and no back-pressure. Control and status pins are plain levels and pulses.

Top module: `fm_track_writer`

## Requirements
- R1: A cell boundary falls on every CELL_DIV-th `ref_tick` pulse counted from the start pulse. `wr_data`, `wr_gate` and `done` change only on the clock edge of a cell boundary.
- R2: Each byte takes 16 cells, most significant bit first. Every bit is a clock cell followed by its data cell, with no framing bits. Ordinary bytes have all clock cells at 1, so a 0x00 byte is the cell pattern 1010101010101010.
- R3: Each sector is written in this order: 6 × 0x00; ID mark; track number; side (0x00 or 0x01); sector number; size code 0x00; 2 ID CRC bytes; 17 × 0x00; data mark; 128 × `fill_byte`; 2 data CRC bytes; 9 × 0x00; 3 × 0xFF. Sectors are numbered 1 to `sector_cnt` in ascending order.
- R4: The ID mark is data 0xFE and the data mark is data 0xFB. Each mark is sent with clock pattern 0xC7 instead of 0xFF.
- R5: Each CRC is CRC-16 with polynomial 0x1021 and preset 0xFFFF. It covers its mark byte and the bytes that follow the mark, and is sent high byte first.
- R6: After the last sector, 0x4E bytes follow until the total byte count equals `track_len`. If the sectors alone reach `track_len`, no filler is written. With `sector_cnt` = 0 the whole track is filler.
- R7: `wr_gate` is high from the first cell to the last cell. At the cell boundary after the last cell it drops, and in that same clock `done` is high for exactly one clock.
- R8: A `stop` pulse while writing ends the track once the byte in progress is complete.
- R9: A `start` pulse while writing is ignored. A `stop` pulse while idle is ignored.
- R10: After reset, `wr_data`, `wr_gate` and `done` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_tick | input | 1 | One-clock pulse at the 1 MHz reference rate |
| start | input | 1 | Begin formatting a track (ignored when busy) |
| stop | input | 1 | End the track at the next byte boundary |
| track_no | input | 8 | Track number written into ID fields |
| side_sel | input | 1 | Side written into ID fields |
| sector_cnt | input | SEC_W | Number of sectors on the track |
| fill_byte | input | 8 | Value of every sector data byte |
| track_len | input | LEN_W | Total bytes to write, including filler |
| wr_data | output | 1 | Current FM cell value |
| wr_gate | output | 1 | High while the track is being written |
| done | output | 1 | One-clock pulse when the track ends |

## Verification
The bench builds the block with CELL_DIV = 2 and keeps every other parameter at its default. This halves the cycles per cell, so several complete multi-sector tracks fit in the run. The tracks cover zero, one, two and three sectors, lengths both above and below the sector total, a mid-track stop, and a restart attempt while busy. The reference ticks are random, which exercises cell pacing under irregular reference pulses.

// File: rtl/fmtw_pkg.sv
package fmtw_pkg;

  typedef enum logic [3:0] {
    SG_PRE, SG_IDAM, SG_IDF, SG_IDCRC, SG_GAP2, SG_DAM,
    SG_DATA, SG_DCRC, SG_GAP3, SG_GAPFF, SG_FILL
  } seg_e;

  typedef enum logic [1:0] { CRC_HOLD, CRC_SEED, CRC_ACC } crc_op_e;

  typedef struct packed {
    logic [7:0] data;
    logic [7:0] clk_pat;
    crc_op_e    op;
  } fm_byte_t;

  localparam logic [7:0]  ID_MARK    = 8'hFE;
  localparam logic [7:0]  DATA_MARK  = 8'hFB;
  localparam logic [7:0]  MARK_CLK   = 8'hC7;
  localparam logic [7:0]  PLAIN_CLK  = 8'hFF;
  localparam logic [7:0]  TRACK_FILL = 8'h4E;
  localparam logic [7:0]  SYNC_BYTE  = 8'h00;
  localparam logic [7:0]  TAIL_BYTE  = 8'hFF;
  localparam logic [7:0]  SIZE_128   = 8'h00;
  localparam logic [15:0] CRC_POLY   = 16'h1021;
  localparam logic [15:0] CRC_PRESET = 16'hFFFF;

  function automatic logic [15:0] crc16_step(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] r;
    logic fb;
    r = c;
    for (int i = 7; i >= 0; i--) begin
      fb = r[15] ^ b[i];
      r = {r[14:0], 1'b0} ^ (fb ? CRC_POLY : 16'h0000);
    end
    return r;
  endfunction

  function automatic logic [15:0] fm_cells(input logic [7:0] cp, input logic [7:0] d);
    logic [15:0] w;
    for (int i = 0; i < 8; i++) begin
      w[2*i+1] = cp[i];
      w[2*i]   = d[i];
    end
    return w;
  endfunction

endpackage

// File: rtl/fm_cell_timer.sv
module fm_cell_timer #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic tick,
  output logic strobe
);
  generate
    if (DIV <= 1) begin : g_direct
      assign strobe = run & tick;
    end else begin : g_count
      localparam int CW = $clog2(DIV);
      localparam logic [CW-1:0] LAST = CW'(DIV - 1);
      logic [CW-1:0] cnt;
      assign strobe = run && tick && (cnt == LAST);
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        cnt <= '0;
        else if (!run)     cnt <= '0;
        else if (tick)     cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
      end
    end
  endgenerate
endmodule

// File: rtl/fm_crc16.sv
module fm_crc16
  import fmtw_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        en,
  input  crc_op_e     op,
  input  logic [7:0]  din,
  output logic [15:0] crc
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) crc <= CRC_PRESET;
    else if (en) begin
      case (op)
        CRC_SEED: crc <= crc16_step(CRC_PRESET, din);
        CRC_ACC:  crc <= crc16_step(crc, din);
        default:  crc <= crc;
      endcase
    end
  end
endmodule

// File: rtl/fm_layout_seq.sv
module fm_layout_seq
  import fmtw_pkg::*;
#(
  parameter int SEC_W    = 5,
  parameter int DATA_LEN = 128,
  parameter int PRE_LEN  = 6,
  parameter int GAP2_LEN = 17,
  parameter int GAP3_LEN = 9,
  parameter int TAIL_LEN = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             init,
  input  logic             adv,
  input  logic [SEC_W-1:0] sec_total,
  input  logic [7:0]       track,
  input  logic             side,
  input  logic [7:0]       fill,
  input  logic [15:0]      crc,
  output fm_byte_t         cur,
  output logic             in_fill
);
  localparam int MAXL = DATA_LEN + PRE_LEN + GAP2_LEN + GAP3_LEN + TAIL_LEN + 8;
  localparam int IW   = $clog2(MAXL);

  seg_e             seg;
  logic [IW-1:0]    idx;
  logic [SEC_W-1:0] sec_idx;
  logic [SEC_W-1:0] sec_lim;

  function automatic logic [IW-1:0] seg_len(input seg_e s);
    case (s)
      SG_PRE:   return IW'(PRE_LEN);
      SG_IDF:   return IW'(4);
      SG_IDCRC: return IW'(2);
      SG_GAP2:  return IW'(GAP2_LEN);
      SG_DATA:  return IW'(DATA_LEN);
      SG_DCRC:  return IW'(2);
      SG_GAP3:  return IW'(GAP3_LEN);
      SG_GAPFF: return IW'(TAIL_LEN);
      default:  return IW'(1);
    endcase
  endfunction

  assign in_fill = (seg == SG_FILL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seg     <= SG_FILL;
      idx     <= '0;
      sec_idx <= '0;
      sec_lim <= '0;
    end else if (init) begin
      seg     <= (sec_total == '0) ? SG_FILL : SG_PRE;
      idx     <= '0;
      sec_idx <= '0;
      sec_lim <= sec_total;
    end else if (adv && seg != SG_FILL) begin
      if (idx == seg_len(seg) - 1'b1) begin
        idx <= '0;
        if (seg == SG_GAPFF) begin
          sec_idx <= sec_idx + 1'b1;
          seg     <= (sec_idx + 1'b1 == sec_lim) ? SG_FILL : SG_PRE;
        end else begin
          seg <= seg_e'(seg + 1'b1);
        end
      end else begin
        idx <= idx + 1'b1;
      end
    end
  end

  always_comb begin
    cur.data    = SYNC_BYTE;
    cur.clk_pat = PLAIN_CLK;
    cur.op      = CRC_HOLD;
    case (seg)
      SG_IDAM: begin cur.data = ID_MARK; cur.clk_pat = MARK_CLK; cur.op = CRC_SEED; end
      SG_DAM:  begin cur.data = DATA_MARK; cur.clk_pat = MARK_CLK; cur.op = CRC_SEED; end
      SG_IDF: begin
        cur.op = CRC_ACC;
        case (idx[1:0])
          2'd0:    cur.data = track;
          2'd1:    cur.data = {7'd0, side};
          2'd2:    cur.data = 8'(sec_idx) + 8'd1;
          default: cur.data = SIZE_128;
        endcase
      end
      SG_DATA:  begin cur.data = fill; cur.op = CRC_ACC; end
      SG_IDCRC, SG_DCRC: cur.data = (idx == '0) ? crc[15:8] : crc[7:0];
      SG_GAPFF: cur.data = TAIL_BYTE;
      SG_FILL:  cur.data = TRACK_FILL;
      default:  cur.data = SYNC_BYTE;
    endcase
  end
endmodule

// File: rtl/fm_cell_shifter.sv
module fm_cell_shifter (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        init,
  input  logic        strobe,
  input  logic        have_byte,
  input  logic [15:0] word,
  output logic        load,
  output logic        finish,
  output logic        wr_data,
  output logic        wr_gate
);
  logic [14:0] rest;
  logic [3:0]  left;

  assign load   = strobe && (left == 4'd0) && have_byte;
  assign finish = strobe && (left == 4'd0) && !have_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rest <= '0; left <= '0; wr_data <= 1'b0; wr_gate <= 1'b0;
    end else if (init) begin
      left <= '0;
    end else if (load) begin
      wr_data <= word[15];
      rest    <= word[14:0];
      left    <= 4'd15;
      wr_gate <= 1'b1;
    end else if (finish) begin
      wr_data <= 1'b0;
      wr_gate <= 1'b0;
    end else if (strobe) begin
      wr_data <= rest[14];
      rest    <= {rest[13:0], 1'b0};
      left    <= left - 1'b1;
    end
  end
endmodule

// File: rtl/fm_track_writer.sv
module fm_track_writer
  import fmtw_pkg::*;
#(
  parameter int CELL_DIV = 4,
  parameter int SEC_W    = 5,
  parameter int LEN_W    = 16,
  parameter int DATA_LEN = 128,
  parameter int PRE_LEN  = 6,
  parameter int GAP2_LEN = 17,
  parameter int GAP3_LEN = 9,
  parameter int TAIL_LEN = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_tick,
  input  logic             start,
  input  logic             stop,
  input  logic [7:0]       track_no,
  input  logic             side_sel,
  input  logic [SEC_W-1:0] sector_cnt,
  input  logic [7:0]       fill_byte,
  input  logic [LEN_W-1:0] track_len,
  output logic             wr_data,
  output logic             wr_gate,
  output logic             done
);
  logic             busy, stop_l, strobe, load, finish, init, in_fill;
  logic [7:0]       track_q, fill_q;
  logic             side_q;
  logic [LEN_W-1:0] len_q, sent;
  logic [15:0]      crc;
  fm_byte_t         cur;

  assign init = start && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; stop_l <= 1'b0; done <= 1'b0;
      track_q <= '0; fill_q <= '0; side_q <= 1'b0; len_q <= '0; sent <= '0;
    end else begin
      done <= finish;
      if (init) begin
        busy <= 1'b1; stop_l <= 1'b0; sent <= '0;
        track_q <= track_no; fill_q <= fill_byte; side_q <= side_sel; len_q <= track_len;
      end else begin
        if (busy && stop) stop_l <= 1'b1;
        if (load)         sent <= sent + 1'b1;
        if (finish)       busy <= 1'b0;
      end
    end
  end

  fm_cell_timer #(.DIV(CELL_DIV)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(busy), .tick(ref_tick), .strobe(strobe)
  );

  fm_layout_seq #(
    .SEC_W(SEC_W), .DATA_LEN(DATA_LEN), .PRE_LEN(PRE_LEN),
    .GAP2_LEN(GAP2_LEN), .GAP3_LEN(GAP3_LEN), .TAIL_LEN(TAIL_LEN)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .init(init), .adv(load), .sec_total(sector_cnt),
    .track(track_q), .side(side_q), .fill(fill_q), .crc(crc),
    .cur(cur), .in_fill(in_fill)
  );

  fm_crc16 u_crc (
    .clk(clk), .rst_n(rst_n), .en(load), .op(cur.op), .din(cur.data), .crc(crc)
  );

  fm_cell_shifter u_shift (
    .clk(clk), .rst_n(rst_n), .init(init), .strobe(strobe),
    .have_byte(!(stop_l || (in_fill && sent >= len_q))),
    .word(fm_cells(cur.clk_pat, cur.data)),
    .load(load), .finish(finish), .wr_data(wr_data), .wr_gate(wr_gate)
  );
endmodule

// File: rtl/fm_track_writer_chk.sv
module fm_track_writer_chk (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic strobe,
  input logic wr_data,
  input logic wr_gate,
  input logic done
);
  p_hold_between_cells_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe |=> ($stable(wr_data) && $stable(wr_gate)));
  p_done_one_clock_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_gate_fall_with_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wr_gate) |-> done);
  p_done_when_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !wr_gate));
  p_no_gate_when_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !wr_gate);
endmodule

bind fm_track_writer fm_track_writer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .strobe(strobe),
  .wr_data(wr_data), .wr_gate(wr_gate), .done(done)
);

// File: tb/sim_fm_track_writer.sv
module sim_fm_track_writer;
  localparam int DIV = 2;
  localparam int DLEN = 128;
  localparam int MAXB = 2048;

  logic clk = 1'b0, rst_n = 1'b0, ref_tick = 1'b0, start = 1'b0, stop = 1'b0;
  logic [7:0] track_no = '0, fill_byte = '0;
  logic side_sel = 1'b0;
  logic [4:0] sector_cnt = '0;
  logic [15:0] track_len = '0;
  logic wr_data, wr_gate, done;

  int n_chk = 0, n_fail = 0, cyc = 0;
  logic cells [0:MAXB*16-1];
  logic [7:0] eb [0:MAXB-1];
  logic [7:0] ec [0:MAXB-1];
  int ek [0:MAXB-1];
  int ecount;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc++;

  fm_track_writer #(.CELL_DIV(DIV)) u0 (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .start(start), .stop(stop),
    .track_no(track_no), .side_sel(side_sel), .sector_cnt(sector_cnt),
    .fill_byte(fill_byte), .track_len(track_len),
    .wr_data(wr_data), .wr_gate(wr_gate), .done(done)
  );

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
    end
  endtask

  function automatic logic [15:0] ref_crc(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] r = c;
    for (int i = 7; i >= 0; i--) begin
      if (r[15] ^ b[i]) r = (r << 1) ^ 16'h1021;
      else r = r << 1;
    end
    return r;
  endfunction

  function automatic logic [15:0] ref_word(input logic [7:0] cp, input logic [7:0] d);
    logic [15:0] w;
    for (int i = 7; i >= 0; i--) w[2*i+1 -: 2] = {cp[i], d[i]};
    return w;
  endfunction

  function automatic void put(input logic [7:0] d, input logic [7:0] cp, input int kind);
    eb[ecount] = d; ec[ecount] = cp; ek[ecount] = kind; ecount++;
  endfunction

  // kinds: 0 layout (R3), 1 mark (R4), 2 crc (R5), 3 end fill (R6)
  function automatic void build(input logic [7:0] trk, input logic sd, input int n,
                                input logic [7:0] fl, input int len);
    logic [15:0] c;
    ecount = 0;
    for (int s = 0; s < n; s++) begin
      for (int i = 0; i < 6; i++) put(8'h00, 8'hFF, 0);
      put(8'hFE, 8'hC7, 1); c = ref_crc(16'hFFFF, 8'hFE);
      put(trk, 8'hFF, 0); c = ref_crc(c, trk);
      put({7'd0, sd}, 8'hFF, 0); c = ref_crc(c, {7'd0, sd});
      put(8'(s + 1), 8'hFF, 0); c = ref_crc(c, 8'(s + 1));
      put(8'h00, 8'hFF, 0); c = ref_crc(c, 8'h00);
      put(c[15:8], 8'hFF, 2); put(c[7:0], 8'hFF, 2);
      for (int i = 0; i < 17; i++) put(8'h00, 8'hFF, 0);
      put(8'hFB, 8'hC7, 1); c = ref_crc(16'hFFFF, 8'hFB);
      for (int i = 0; i < DLEN; i++) begin put(fl, 8'hFF, 0); c = ref_crc(c, fl); end
      put(c[15:8], 8'hFF, 2); put(c[7:0], 8'hFF, 2);
      for (int i = 0; i < 9; i++) put(8'h00, 8'hFF, 0);
      for (int i = 0; i < 3; i++) put(8'hFF, 8'hFF, 0);
    end
    while (ecount < len) put(8'h4E, 8'hFF, 3);
  endfunction

  task automatic run_track(input string name, input int n, input int len,
                           input int stop_at, input int start_at);
    int tc = 0, nc = 0, kstop = -1, bad1 = 0, bad7 = 0, nb, expb;
    bit tk, ended = 0, end_done = 0, did = 0;
    logic pg, pd;
    logic [7:0] trk = 8'($urandom % 80);
    logic sd = 1'($urandom);
    logic [7:0] fl = 8'($urandom);
    int errs [4] = '{0, 0, 0, 0};
    int seen [4] = '{0, 0, 0, 0};
    int fa [4], fe [4];
    build(trk, sd, n, fl, len);
    @(negedge clk);
    track_no = trk; side_sel = sd; fill_byte = fl; sector_cnt = 5'(n);
    track_len = 16'(len); start = 1; ref_tick = 0;
    @(negedge clk); start = 0;
    while (!ended && cyc < 195000) begin
      tk = ($urandom % 4) != 0; stop = 0; start = 0;
      if (stop_at >= 0 && kstop < 0 && nc >= stop_at) begin stop = 1; tk = 0; kstop = nc; end
      if (start_at >= 0 && !did && nc >= start_at) begin
        start = 1; track_no = ~trk; sector_cnt = 5'd1; tk = 0; did = 1;
      end
      ref_tick = tk; pg = wr_gate; pd = wr_data;
      @(posedge clk); #1;
      if (tk) tc++;
      if (tk && tc == DIV) begin
        tc = 0;
        if (wr_gate) begin
          if (nc < MAXB*16) cells[nc] = wr_data;
          nc++;
          if (done) bad7++;
        end else begin
          ended = 1; end_done = done;
        end
      end else if (wr_gate !== pg || wr_data !== pd || done !== 1'b0) bad1++;
      @(negedge clk);
    end
    stop = 0; start = 0; ref_tick = 0;
    chk(bad1 == 0, "R1", {name, " outputs moved off a cell boundary"}, bad1, 0);
    chk(end_done && bad7 == 0, "R7", {name, " done with gate drop only"}, {end_done, 8'(bad7)}, 1);
    @(posedge clk); #1;
    chk(done == 1'b0, "R7", {name, " done lasts one clock"}, done, 0);
    expb = (kstop >= 0) ? (kstop + 15) / 16 : ecount;
    chk(nc == expb * 16, (kstop >= 0) ? "R8" : "R6", {name, " cell count"}, nc, expb * 16);
    nb = nc / 16;
    if (nb > MAXB) nb = MAXB;
    if (nb > ecount) nb = ecount;
    for (int b = 0; b < nb; b++) begin
      logic [15:0] got, want;
      for (int j = 0; j < 16; j++) got[15-j] = cells[b*16+j];
      want = ref_word(ec[b], eb[b]);
      seen[ek[b]]++;
      if (got !== want) begin
        if (errs[ek[b]] == 0) begin fa[ek[b]] = got; fe[ek[b]] = want; end
        errs[ek[b]]++;
      end
    end
    if (nb > 0) begin
      logic [15:0] g0;
      for (int j = 0; j < 16; j++) g0[15-j] = cells[j];
      chk(g0 == ref_word(ec[0], eb[0]), "R2", {name, " first byte cell order"}, g0, ref_word(ec[0], eb[0]));
    end
    if (seen[0] > 0) chk(errs[0] == 0, "R3", {name, " sector layout bytes"}, fa[0], fe[0]);
    if (seen[1] > 0) chk(errs[1] == 0, "R4", {name, " address marks"}, fa[1], fe[1]);
    if (seen[2] > 0) chk(errs[2] == 0, "R5", {name, " CRC bytes"}, fa[2], fe[2]);
    if (seen[3] > 0) chk(errs[3] == 0, "R6", {name, " end-of-track filler"}, fa[3], fe[3]);
    if (start_at >= 0) chk(errs[0] == 0 && nc == expb * 16, "R9", {name, " start while busy ignored"}, errs[0], 0);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(wr_data === 1'b0 && wr_gate === 1'b0 && done === 1'b0, "R10", "outputs in reset",
        {wr_data, wr_gate, done}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(wr_gate === 1'b0 && done === 1'b0, "R10", "idle after reset", {wr_gate, done}, 0);
    // R9: stop while idle
    stop = 1; @(negedge clk); stop = 0;
    repeat (4) begin ref_tick = 1; @(negedge clk); end
    chk(wr_gate === 1'b0 && done === 1'b0, "R9", "stop while idle ignored", {wr_gate, done}, 0);
    run_track("one sector", 1, 250, -1, -1);
    run_track("len below sectors", 2, 300, -1, -1);
    run_track("three sectors restart", 3, 530, -1, 3000);
    run_track("no sectors", 0, 12, -1, -1);
    run_track("stopped", 2, 400, 2001, -1);
    if (cyc >= 195000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 195000);
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    wait (cyc >= 199000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 199000);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule